// File: doc/BRIEF.md
# Wake Interrupt Sense Converter

This block sits between a set of wake-capable interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each input lane has its own 3-bit sense code and an enable bit. The lane synchronises its pin, then turns it into the form the controller accepts. An active-low level is inverted into an active-high level. A falling edge becomes a one-cycle rising pulse. A dual-edge input gives one pulse for every transition in either direction.

Software sets up the lanes through a plain 32-bit register port with a write strobe and a read strobe. The enable bits are packed 32 to a word, starting at byte offset 0x10. Each lane then has its own configuration word, starting at offset 0x110 with a stride of 4 bytes. Read data comes back registered, one cycle after the read strobe.

Edges are always detected on the raw synchronised pin, not on the polarity-corrected signal. Because of this, rewriting a lane's sense code cannot create a false edge event. Only a level lane's output follows its new polarity. The register port and the lane outputs are control signals with no flow control, so there is no valid/ready handshake and no back-pressure.

Top module: `wake_sense_conv`

## Requirements
- R1: Lane i's enable is bit (i mod 32) of the enable word at byte address 0x10 + 4*(i/32). These words read back what was written. Bit positions with no lane behind them read 0.
- R2: A lane whose enable is 0 drives 0 on its output. An edge that happens while the lane is disabled is not kept: enabling the lane afterwards produces no pulse.
- R3: Lane i's sense code is bits [2:0] of the word at byte address 0x110 + 4*i. Bits [31:3] of that word read as 0.
- R4: With code 110 (rising), each low-to-high change on the pin gives a one-cycle output pulse. The pulse appears 3 clock edges after the pin changes.
- R5: With code 010 (falling), each high-to-low change on the pin gives a one-cycle output pulse with the same latency as R4. A rising change gives nothing.
- R6: With code 111 (dual), every change on the pin, in either direction, gives a one-cycle output pulse.
- R7: With code 100 (level high), the output follows the pin 3 edges later. With code 000 (level low), the output is the inverted pin. A newly written level code takes effect on the output 2 edges after the write strobe.
- R8: Codes 001, 011 and 101 hold the output at 0.
- R9: After reset, every enable bit and every sense code is 0, and every output is 0.
- R10: Rewriting a lane's sense code while its pin is steady never produces an edge pulse.
- R11: The read strobe returns data on rdata_o in the next cycle. In a cycle that follows no read, rdata_o is 0. Unmapped addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| pin_i | input | N_IN | Raw asynchronous interrupt pins |
| irq_o | output | N_IN | Normalised interrupt outputs to the downstream controller |

## Verification
A pin change reaches irq_o 3 clock edges after the bench drives it: two synchroniser stages, then the output register. A register write changes irq_o 2 edges after its strobe, and read data is due 1 edge after its strobe. The driver pushes each expected value into the scoreboard with its due cycle, computed as the current cycle plus that fixed latency. The monitor compares each value only on the falling edge of its due cycle. Pulse expectations are also placed one cycle before and one cycle after the due cycle, so a pulse that comes early, comes late or lasts too long is caught.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [2:0] {
    SENSE_LVL_LO = 3'b000,
    SENSE_FALL   = 3'b010,
    SENSE_LVL_HI = 3'b100,
    SENSE_RISE   = 3'b110,
    SENSE_BOTH   = 3'b111
  } sense_e;

  localparam int unsigned DATA_W = 32;

  function automatic logic sense_is_edge(input logic [2:0] code);
    return (code == SENSE_RISE) || (code == SENSE_FALL) || (code == SENSE_BOTH);
  endfunction

  function automatic logic sense_is_unused(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b011) || (code == 3'b101);
  endfunction

endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wsc_lane.sv
module wsc_lane
  import wsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       en_i,
  input  logic [2:0] cfg_i,
  output logic       out_o
);
  logic sync_s;
  logic prev_q;
  logic cond_d;
  logic out_q;

  wsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (sync_s)
  );

  // Previous sample always tracks the raw pin, enabled or not, so that
  // neither enabling nor re-typing a lane can fabricate an edge.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_s;

  always_comb begin
    unique case (cfg_i)
      SENSE_LVL_LO: cond_d = ~sync_s;
      SENSE_LVL_HI: cond_d = sync_s;
      SENSE_RISE:   cond_d = sync_s & ~prev_q;
      SENSE_FALL:   cond_d = ~sync_s & prev_q;
      SENSE_BOTH:   cond_d = sync_s ^ prev_q;
      default:      cond_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= en_i & cond_d;

  assign out_o = out_q;

  // R2: a disabled lane is silent in the following cycle
  a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !out_o);

  // R4: a rising pulse never lasts two cycles while the code stays rising
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o && cfg_i == SENSE_RISE && $past(cfg_i) == SENSE_RISE) |=> !out_o);

  // R8: unused codes keep the output low
  a_r8_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    sense_is_unused(cfg_i) |=> !out_o);

  // R10: a steady pin never yields an edge pulse, whatever code was just written
  a_r10_steady_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_is_edge(cfg_i) && $stable(sync_s)) |=> !out_o);

endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
  import wsc_pkg::*;
#(
  parameter int unsigned N_IN     = 40,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned EN_BASE  = 'h10,
  parameter int unsigned CFG_BASE = 'h110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N_IN-1:0]       en_o,
  output logic [N_IN-1:0][2:0]  cfg_o
);
  localparam int unsigned N_WORDS = (N_IN + 31) / 32;
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * N_WORDS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * N_IN);

  logic                 aligned;
  logic                 en_hit;
  logic                 cfg_hit;
  logic [ADDR_W-1:0]    en_off;
  logic [ADDR_W-1:0]    cfg_off;
  logic [31:0]          en_widx;
  logic [31:0]          cfg_idx;
  logic [N_IN-1:0]      en_q;
  logic [N_IN-1:0][2:0] cfg_q;
  logic [DATA_W-1:0]    rd_word;
  logic [DATA_W-1:0]    rdata_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign en_off  = addr_i - EN_LO;
  assign cfg_off = addr_i - CFG_LO;
  assign en_hit  = aligned && (addr_i >= EN_LO) && (addr_i < EN_HI);
  assign cfg_hit = aligned && (addr_i >= CFG_LO) && (addr_i < CFG_HI);
  assign en_widx = 32'(en_off[ADDR_W-1:2]);
  assign cfg_idx = 32'(cfg_off[ADDR_W-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_IN; i++) begin
        if (en_hit && en_widx == 32'(i / 32)) en_q[i] <= wdata_i[i % 32];
        if (cfg_hit && cfg_idx == 32'(i))     cfg_q[i] <= wdata_i[2:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (en_hit && en_widx == 32'(i / 32)) rd_word[i % 32] = en_q[i];
      if (cfg_hit && cfg_idx == 32'(i))     rd_word[2:0]    = cfg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
    else              rdata_q <= '0;

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign cfg_o   = cfg_q;

  // R1: a write to the first enable word lands in lane 0's enable
  a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == EN_LO) |=> (en_o[0] == $past(wdata_i[0])));

  // R3: a write to lane 0's config word lands in its sense code
  a_r3_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CFG_LO) |=> (cfg_o[0] == $past(wdata_i[2:0])));

  // R11: read data is zero after a cycle without a read strobe
  a_r11_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (rdata_o == '0));

endmodule

// File: rtl/wake_sense_conv.sv
module wake_sense_conv
  import wsc_pkg::*;
#(
  parameter int unsigned N_IN        = 40,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned EN_BASE     = 'h10,
  parameter int unsigned CFG_BASE    = 'h110,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_IN-1:0]   pin_i,
  output logic [N_IN-1:0]   irq_o
);
  logic [N_IN-1:0]      lane_en;
  logic [N_IN-1:0][2:0] lane_cfg;

  wsc_regs #(
    .N_IN    (N_IN),
    .ADDR_W  (ADDR_W),
    .EN_BASE (EN_BASE),
    .CFG_BASE(CFG_BASE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .en_o   (lane_en),
    .cfg_o  (lane_cfg)
  );

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
      wsc_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i(pin_i[i]),
        .en_i (lane_en[i]),
        .cfg_i(lane_cfg[i]),
        .out_o(irq_o[i])
      );
    end
  endgenerate

  // R9: outputs come out of reset low
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));

endmodule

// File: tb/wake_sense_conv_tb_top.sv
module wake_sense_conv_tb_top;
  localparam int N = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  irq;

  always #10 clk = ~clk;

  wake_sense_conv #(.N_IN(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pins), .irq_o(irq)
  );

  typedef struct {
    int          due;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    cyc = 0;
  int    t0 = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pop and compare items due in this cycle
  always @(negedge clk) begin
    for (int k = exp_q.size() - 1; k >= 0; k--) begin
      if (exp_q[k].due == cyc) begin
        if (exp_q[k].idx < 0) check(exp_q[k].req, rdata, exp_q[k].exp);
        else check(exp_q[k].req, 32'(irq[exp_q[k].idx]), exp_q[k].exp);
        exp_q.delete(k);
      end
    end
  end

  task automatic push(input int off, input int idx, input logic [31:0] exp, input string req);
    item_t it;
    it.due = t0 + off; it.idx = idx; it.exp = exp; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    t0 = cyc;
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    step();
    wr_en = 1'b1; addr = AW'(a); wdata = d;
  endtask

  task automatic bus_rd(input int a, input logic [31:0] exp, input string req);
    step();
    rd_en = 1'b1; addr = AW'(a);
    push(1, -1, exp, req);
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    step();
    pins = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  function automatic int cfg_a(input int i);
    return 'h110 + 4 * i;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R9 outputs after reset", 32'(irq), 32'h0);
    bus_rd('h10, 32'h0, "R9 enable word 0 after reset");
    bus_rd(cfg_a(5), 32'h0, "R9 config 5 after reset");
    push(2, -1, 32'h0, "R11 rdata zero without read");
    idle(2);

    // lane types
    bus_wr(cfg_a(0), 32'h6);
    bus_wr(cfg_a(1), 32'h2);
    bus_wr(cfg_a(2), 32'h7);
    bus_wr(cfg_a(3), 32'h4);
    bus_wr(cfg_a(4), 32'h0);
    bus_wr(cfg_a(5), 32'h5);
    bus_wr(cfg_a(6), 32'h6);
    bus_wr(cfg_a(33), 32'h6);
    bus_wr('h10, 32'h0000_003F);
    push(2, 4, 1, "R7 level low with pin low");
    push(2, 0, 0, "R2 enable with steady pin no pulse");
    bus_wr('h14, 32'hFFFF_FFFF);
    idle(3);
    bus_rd('h14, 32'h0000_00FF, "R1 enable word 1 only populated bits");
    bus_rd('h10, 32'h0000_003F, "R1 enable word 0 readback");
    bus_rd(cfg_a(2), 32'h7, "R3 config readback");
    bus_wr(cfg_a(7), 32'hFFFF_FFF9);
    bus_rd(cfg_a(7), 32'h1, "R3 upper config bits read zero");
    bus_wr('h0, 32'hFFFF_FFFF);
    bus_rd('h0, 32'h0, "R11 unmapped address reads zero");
    bus_rd('h18, 32'h0, "R11 beyond enable words reads zero");
    bus_rd('h10, 32'h0000_003F, "R11 unmapped write no effect");
    idle(3);

    // pins rise on lanes 0..6 and 33
    set_pins(N'(64'h2_0000_007F));
    push(2, 0, 0, "R4 no early pulse");
    push(3, 0, 1, "R4 rising pulse");
    push(4, 0, 0, "R4 pulse one cycle");
    push(3, 1, 0, "R5 falling ignores rise");
    push(3, 2, 1, "R6 dual on rise");
    push(4, 2, 0, "R6 dual pulse one cycle");
    push(3, 3, 1, "R7 level high follows");
    push(4, 3, 1, "R7 level high holds");
    push(3, 4, 0, "R7 level low inverted");
    push(3, 5, 0, "R8 unused code 101 low");
    push(3, 6, 0, "R2 disabled lane silent");
    push(3, 33, 1, "R1 second word lane pulse");
    push(4, 33, 0, "R4 second word lane one cycle");
    idle(6);
    bus_wr('h10, 32'h0000_007F);
    push(2, 6, 0, "R2 no captured edge after enable");
    push(3, 6, 0, "R2 no captured edge after enable +1");
    idle(3);

    // pins fall
    set_pins('0);
    push(3, 0, 0, "R4 rising ignores fall");
    push(3, 1, 1, "R5 falling pulse");
    push(4, 1, 0, "R5 pulse one cycle");
    push(3, 2, 1, "R6 dual on fall");
    push(4, 2, 0, "R6 dual fall one cycle");
    push(3, 3, 0, "R7 level high drops");
    push(3, 4, 1, "R7 level low asserts");
    push(3, 6, 0, "R4 lane 6 ignores fall");
    idle(6);

    // reconfigure with steady pins
    bus_wr(cfg_a(0), 32'h2);
    push(2, 0, 0, "R10 retype to falling no pulse");
    push(3, 0, 0, "R10 retype to falling no pulse +1");
    bus_wr(cfg_a(6), 32'h7);
    push(2, 6, 0, "R10 retype to dual no pulse");
    bus_wr(cfg_a(3), 32'h0);
    push(2, 3, 1, "R7 level retype takes effect");
    bus_wr(cfg_a(4), 32'h6);
    push(2, 4, 0, "R10 level low to rising no pulse");
    push(3, 4, 0, "R10 level low to rising no pulse +1");
    bus_wr(cfg_a(5), 32'h1);
    push(2, 5, 0, "R8 unused code 001 low");
    bus_wr(cfg_a(5), 32'h3);
    push(2, 5, 0, "R8 unused code 011 low");
    idle(3);

    // dual edge back-to-back and disable
    set_pins(N'(64'h4));
    idle(1);
    set_pins('0);
    push(3, 2, 1, "R6 dual second transition pulse");
    push(4, 2, 0, "R6 dual settles");
    idle(5);
    bus_wr('h10, 32'h0);
    push(2, 3, 0, "R2 disable forces level output low");
    idle(6);

    check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule